// File: doc/BRIEF.md
# Reset Sequencer with Boot-Mode Capture

This block governs how a small microcontroller's system bus enters and leaves reset. An active-low reset request from outside the chip passes through a two-flop synchroniser and a minimum-length filter. When the request is accepted while a bus cycle is running, the block waits for that cycle to end, or for a bus-monitor timeout, before it asserts the internal reset. This lets an in-flight write complete. While the internal reset is asserted, the bus is told to float its pins and no bus cycle is allowed to start.

When the request goes away, the internal reset deasserts. On that same clock edge the block captures the pin-strapped boot configuration from the data lines and the clock-mode pin. Each line has a weak pull-up, so a line read high keeps the default function and a line read low selects the alternate one. The captured configuration is decoded into outputs that hold until the next reset. A fixed count of clocks then passes before the first bus cycle is allowed. The port logic and chip-select logic use the internal reset to put general-purpose pins into input mode with their alternate functions off.

Top module: `rsm_top`

## Requirements
- R1: A low level on `ext_rst_n` lasting fewer than MIN_ASSERT clocks never asserts the internal reset. A low level lasting MIN_ASSERT clocks or more asserts it.
- R2: If `bus_busy` is high when the request is accepted, `int_rst_n` stays high until `bus_busy` has been sampled low. It then falls on the next clock.
- R3: If `bus_busy` stays high, `int_rst_n` falls BUS_TMO clocks after the deferral begins.
- R4: While `int_rst_n` is low, `bus_hiz` is 1 and `bus_go` is 0.
- R5: `bus_go` rises exactly FIRST_DLY clocks after `int_rst_n` rises, provided no new request is accepted in between.
- R6: `boot_8bit` is 1 when data bit 0 was captured low, and 0 (16-bit boot port) when it was captured high.
- R7: `xaddr_sel[i]` is 1 when data bits 3 through 3+i were all captured low (i = 0..4). Bit i hands address line 19+i to the pin that otherwise carries chip select 6+i. The first high bit from bit 3 upward ends the run, and every higher selection is then 0.
- R8: `test_en` is 1 when data bit 11 was captured low. `clk_ext` is 1 (external oscillator) when `modclk_in` was captured low, and 0 (internal VCO) when it was captured high.
- R9: The configuration is captured on the edge where `int_rst_n` rises. Later changes on `data_in` or `modclk_in` leave the outputs unchanged until the next reset.
- R10: While `por_n` is low, `int_rst_n` is 0, `bus_hiz` is 1, `bus_go` is 0, and all configuration outputs are 0 (the default functions).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External reset request, active low, asynchronous to clk |
| bus_busy | input | 1 | A bus cycle is in progress |
| data_in | input | DW | Data-line levels used as mode straps |
| modclk_in | input | 1 | Clock-mode strap pin |
| int_rst_n | output | 1 | Internal reset to the rest of the system, active low |
| bus_hiz | output | 1 | Float the bus pins or drive them inactive |
| bus_go | output | 1 | Bus cycles are permitted |
| boot_8bit | output | 1 | Boot chip-select port is 8 bits wide |
| xaddr_sel | output | 5 | Per-pin address-line selection, thermometer coded |
| test_en | output | 1 | Test mode enabled |
| clk_ext | output | 1 | System clock taken from the external oscillator |

## Verification
The bench builds the block with MIN_ASSERT = 4, BUS_TMO = 16 and FIRST_DLY = 10. With these values, a request one clock short of the filter length can be tried, and a bus cycle held busy runs past the monitor timeout within a few dozen clocks. The release-to-first-cycle window is also checked to the exact clock. A range of strap patterns is captured: the all-default pattern, each thermometer depth, a broken thermometer run, test mode, and the external clock. After each capture the straps are scrambled to show that the latched values hold.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

  // number of pins that can trade a chip select for an address line
  localparam int XA_N   = 5;
  // data bit that starts the address-line thermometer run
  localparam int XA_LSB = 3;
  // data bit choosing boot port width, data bit enabling test mode
  localparam int BW_BIT = 0;
  localparam int TM_BIT = 11;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_DEFER  = 2'd1,
    ST_HOLD   = 2'd2,
    ST_SETTLE = 2'd3
  } rsm_state_e;

  typedef struct packed {
    logic            boot_8bit;
    logic [XA_N-1:0] xaddr_sel;
    logic            test_en;
    logic            clk_ext;
  } rsm_cfg_t;

endpackage

// File: rtl/rsm_req_filter.sv
module rsm_req_filter #(
  parameter int MIN_ASSERT = 8
) (
  input  logic clk,
  input  logic por_n,
  input  logic req_n,
  output logic accepted
);
  localparam int CW = $clog2(MIN_ASSERT + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_ASSERT);

  logic          meta_q, sync_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= req_n;
      sync_q <= meta_q;
    end
  end

  // length of the current low run, saturating at the acceptance limit
  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (sync_q)
      cnt_d = '0;
    else if (cnt_q != CMAX)
      cnt_d = cnt_q + 1'b1;
    else
      cnt_en = 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      cnt_q <= CMAX;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign accepted = (cnt_q == CMAX);

endmodule

// File: rtl/rsm_ctrl.sv
module rsm_ctrl
  import rsm_pkg::*;
#(
  parameter int BUS_TMO   = 256,
  parameter int FIRST_DLY = 10
) (
  input  logic clk,
  input  logic por_n,
  input  logic accepted,
  input  logic bus_busy,
  output logic int_rst_n,
  output logic bus_hiz,
  output logic bus_go,
  output logic cap_en
);
  localparam int TMAX = (BUS_TMO > FIRST_DLY) ? BUS_TMO : FIRST_DLY;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(BUS_TMO - 1);
  localparam logic [TW-1:0] DLY_LAST = TW'(FIRST_DLY - 1);

  rsm_state_e    st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    unique case (st_q)
      ST_RUN: begin
        if (accepted) begin
          tmr_d = '0;
          st_d  = bus_busy ? ST_DEFER : ST_HOLD;
        end
      end
      ST_DEFER: begin
        tmr_d = tmr_q + 1'b1;
        if (!bus_busy || (tmr_q == TMO_LAST))
          st_d = ST_HOLD;
      end
      ST_HOLD: begin
        tmr_d = '0;
        if (!accepted)
          st_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (accepted)
          st_d = ST_HOLD;
        else if (tmr_q == DLY_LAST)
          st_d = ST_RUN;
        else
          tmr_d = tmr_q + 1'b1;
      end
      default: st_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q  <= ST_HOLD;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end

  assign int_rst_n = (st_q != ST_HOLD);
  assign bus_hiz   = (st_q == ST_HOLD);
  assign bus_go    = (st_q == ST_RUN) || (st_q == ST_DEFER);
  assign cap_en    = (st_q == ST_HOLD) && !accepted;

endmodule

// File: rtl/rsm_mode_latch.sv
module rsm_mode_latch
  import rsm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          cap_en,
  input  logic [DW-1:0] data_in,
  input  logic          modclk_in,
  output rsm_cfg_t      cfg
);
  rsm_cfg_t        cfg_q, cfg_d;
  logic [XA_N-1:0] run_low;

  // thermometer run of low lines starting at XA_LSB
  assign run_low[0] = !data_in[XA_LSB];
  for (genvar i = 1; i < XA_N; i++) begin : g_therm
    assign run_low[i] = run_low[i-1] & !data_in[XA_LSB + i];
  end

  always_comb begin
    cfg_d.boot_8bit = !data_in[BW_BIT];
    cfg_d.xaddr_sel = run_low;
    cfg_d.test_en   = !data_in[TM_BIT];
    cfg_d.clk_ext   = !modclk_in;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      cfg_q <= '0;
    else if (cap_en)
      cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/rsm_top.sv
module rsm_top
  import rsm_pkg::*;
#(
  parameter int DW         = 16,
  parameter int MIN_ASSERT = 8,
  parameter int BUS_TMO    = 256,
  parameter int FIRST_DLY  = 10
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            ext_rst_n,
  input  logic            bus_busy,
  input  logic [DW-1:0]   data_in,
  input  logic            modclk_in,
  output logic            int_rst_n,
  output logic            bus_hiz,
  output logic            bus_go,
  output logic            boot_8bit,
  output logic [XA_N-1:0] xaddr_sel,
  output logic            test_en,
  output logic            clk_ext
);
  logic     accepted;
  logic     cap_en;
  rsm_cfg_t cfg;

  rsm_req_filter #(.MIN_ASSERT(MIN_ASSERT)) u_filt (
    .clk      (clk),
    .por_n    (por_n),
    .req_n    (ext_rst_n),
    .accepted (accepted)
  );

  rsm_ctrl #(.BUS_TMO(BUS_TMO), .FIRST_DLY(FIRST_DLY)) u_ctrl (
    .clk       (clk),
    .por_n     (por_n),
    .accepted  (accepted),
    .bus_busy  (bus_busy),
    .int_rst_n (int_rst_n),
    .bus_hiz   (bus_hiz),
    .bus_go    (bus_go),
    .cap_en    (cap_en)
  );

  rsm_mode_latch #(.DW(DW)) u_mode (
    .clk       (clk),
    .por_n     (por_n),
    .cap_en    (cap_en),
    .data_in   (data_in),
    .modclk_in (modclk_in),
    .cfg       (cfg)
  );

  assign boot_8bit = cfg.boot_8bit;
  assign xaddr_sel = cfg.xaddr_sel;
  assign test_en   = cfg.test_en;
  assign clk_ext   = cfg.clk_ext;

endmodule

// File: rtl/rsm_checker.sv
module rsm_checker
  import rsm_pkg::*;
#(
  parameter int DW         = 16,
  parameter int BUS_TMO    = 256,
  parameter int FIRST_DLY  = 10
) (
  input logic            clk,
  input logic            por_n,
  input logic            bus_busy,
  input logic [DW-1:0]   data_in,
  input logic            int_rst_n,
  input logic            bus_hiz,
  input logic            bus_go,
  input logic            boot_8bit,
  input logic [XA_N-1:0] xaddr_sel,
  input logic            test_en,
  input logic            clk_ext
);
  localparam int BW = $clog2(BUS_TMO + 2);
  localparam int RW = $clog2(FIRST_DLY + 2);

  logic [BW-1:0] busy_run;
  logic [RW-1:0] rel_cnt;

  // consecutive clocks with bus_busy high
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      busy_run <= '0;
    else if (!bus_busy)
      busy_run <= '0;
    else if (busy_run != BW'(BUS_TMO + 1))
      busy_run <= busy_run + 1'b1;
  end

  // clocks since the internal reset was released
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      rel_cnt <= '0;
    else if (!int_rst_n)
      rel_cnt <= '0;
    else if (rel_cnt != RW'(FIRST_DLY + 1))
      rel_cnt <= rel_cnt + 1'b1;
  end

  a_r2_defer_bus_cycle: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(int_rst_n) && $past(bus_go)) |->
      (!$past(bus_busy) || ($past(busy_run) >= BW'(BUS_TMO - 1))));

  a_r4_bus_idle_in_reset: assert property (@(posedge clk) disable iff (!por_n)
    !int_rst_n |-> (bus_hiz && !bus_go));

  a_r5_first_cycle_delay: assert property (@(posedge clk) disable iff (!por_n)
    $rose(bus_go) |-> (rel_cnt == RW'(FIRST_DLY)));

  a_r9_cfg_held: assert property (@(posedge clk) disable iff (!por_n)
    (int_rst_n && $past(int_rst_n)) |->
      $stable({boot_8bit, xaddr_sel, test_en, clk_ext}));

  // R7: the address-line selection is always a thermometer code
  a_r7_thermometer: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(xaddr_sel + 1'b1) || (xaddr_sel == '1));

endmodule

bind rsm_top rsm_checker #(
  .DW        (DW),
  .BUS_TMO   (BUS_TMO),
  .FIRST_DLY (FIRST_DLY)
) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .bus_busy  (bus_busy),
  .data_in   (data_in),
  .int_rst_n (int_rst_n),
  .bus_hiz   (bus_hiz),
  .bus_go    (bus_go),
  .boot_8bit (boot_8bit),
  .xaddr_sel (xaddr_sel),
  .test_en   (test_en),
  .clk_ext   (clk_ext)
);

// File: tb/rsm_top_tb.sv
`timescale 1ns/1ps
module rsm_top_tb;
  import rsm_pkg::*;

  localparam int DW    = 16;
  localparam int MIN_A = 4;
  localparam int TMO   = 16;
  localparam int DLY   = 10;

  logic            clk = 1'b0;
  logic            por_n, ext_rst_n, bus_busy, modclk_in;
  logic [DW-1:0]   data_in;
  logic            int_rst_n, bus_hiz, bus_go, boot_8bit, test_en, clk_ext;
  logic [XA_N-1:0] xaddr_sel;
  logic [7:0]      cfg_now;

  always #2.5 clk = ~clk;

  rsm_top #(.DW(DW), .MIN_ASSERT(MIN_A), .BUS_TMO(TMO), .FIRST_DLY(DLY)) u_dut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .bus_busy(bus_busy),
    .data_in(data_in), .modclk_in(modclk_in), .int_rst_n(int_rst_n),
    .bus_hiz(bus_hiz), .bus_go(bus_go), .boot_8bit(boot_8bit),
    .xaddr_sel(xaddr_sel), .test_en(test_en), .clk_ext(clk_ext)
  );

  assign cfg_now = {boot_8bit, xaddr_sel, test_en, clk_ext};

  int         n_vec = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;
  logic [7:0] exp_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected configuration from the requirements R6, R7, R8
  function automatic logic [7:0] exp_cfg(input logic [DW-1:0] p, input logic mc);
    logic [4:0] m;
    logic       run;
    run = 1'b1;
    for (int i = 0; i < 5; i++) begin
      run  = run & !p[3+i];
      m[i] = run;
    end
    return {!p[0], m, !p[11], !mc};
  endfunction

  // monitor: pops the expected capture at each release, times the first cycle
  initial begin : mon
    logic       prev;
    logic       active;
    int         cnt;
    logic [7:0] cur;
    prev = 1'b0; active = 1'b0; cnt = 0; cur = '0;
    forever begin
      @(negedge clk);
      if (!por_n) begin
        prev = 1'b0; active = 1'b0;
      end else begin
        if (int_rst_n && !prev) begin
          if (exp_q.size() == 0) begin
            chk("R9 release without expected capture", 32'd1, 32'd0);
            cur = cfg_now;
          end else begin
            cur = exp_q.pop_front();
            chk("R6 R7 R8 cfg at release", 32'(cfg_now), 32'(cur));
          end
          chk("R5 no bus cycle at release", 32'(bus_go), 32'd0);
          active = 1'b1;
          cnt = 0;
        end else if (active) begin
          cnt++;
          if (bus_go) begin
            chk("R5 first-cycle delay", 32'(cnt), 32'(DLY));
            chk("R9 cfg held after strap change", 32'(cfg_now), 32'(cur));
            active = 1'b0;
          end else if (!int_rst_n) begin
            active = 1'b0;
          end
        end
        prev = int_rst_n;
      end
    end
  end

  task automatic wait_go();
    for (int i = 0; i < 60; i++) begin
      if (bus_go) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  // mode 0: bus idle, 1: bus busy then drops, 2: bus busy past timeout
  task automatic run_reset(input logic [DW-1:0] pat, input logic mc, input int mode);
    @(negedge clk);
    data_in   = pat;
    modclk_in = mc;
    exp_q.push_back(exp_cfg(pat, mc));
    bus_busy  = (mode != 0);
    ext_rst_n = 1'b0;
    if (mode == 0) begin
      repeat (MIN_A + 5) @(negedge clk);
      chk("R1 held request asserts reset", 32'(int_rst_n), 32'd0);
    end else if (mode == 1) begin
      repeat (MIN_A + 6) @(negedge clk);
      chk("R2 reset deferred while busy", 32'(int_rst_n), 32'd1);
      bus_busy = 1'b0;
      repeat (2) @(negedge clk);
      chk("R2 reset after bus cycle ends", 32'(int_rst_n), 32'd0);
    end else begin
      repeat (MIN_A + 3 + TMO - 2) @(negedge clk);
      chk("R3 reset still deferred before timeout", 32'(int_rst_n), 32'd1);
      repeat (4) @(negedge clk);
      chk("R3 reset forced by timeout", 32'(int_rst_n), 32'd0);
      bus_busy = 1'b0;
    end
    chk("R4 bus floated in reset", 32'(bus_hiz), 32'd1);
    chk("R4 no bus cycle in reset", 32'(bus_go), 32'd0);
    repeat (3) @(negedge clk);
    ext_rst_n = 1'b1;
    repeat (6) @(negedge clk);
    data_in   = ~pat;
    modclk_in = ~mc;
    wait_go();
  endtask

  initial begin : wdog
    repeat (100000) @(negedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : drv
    por_n     = 1'b0;
    ext_rst_n = 1'b1;
    bus_busy  = 1'b0;
    modclk_in = 1'b1;
    data_in   = '1;
    exp_q.push_back(exp_cfg('1, 1'b1));
    repeat (4) @(negedge clk);
    chk("R10 int_rst_n in power-on reset", 32'(int_rst_n), 32'd0);
    chk("R10 bus_hiz in power-on reset", 32'(bus_hiz), 32'd1);
    chk("R10 bus_go in power-on reset", 32'(bus_go), 32'd0);
    chk("R10 default cfg in power-on reset", 32'(cfg_now), 32'd0);
    por_n = 1'b1;
    wait_go();

    // R1: pulse one clock shorter than the filter limit is ignored
    ext_rst_n = 1'b0;
    repeat (MIN_A - 1) @(negedge clk);
    ext_rst_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!int_rst_n) break;
    end
    chk("R1 short pulse ignored", 32'(int_rst_n), 32'd1);
    chk("R1 bus still running", 32'(bus_go), 32'd1);

    run_reset(16'hFFFE, 1'b1, 0);  // R6 8-bit boot port
    run_reset(16'hFFF7, 1'b1, 0);  // R7 one address line
    run_reset(16'hFFE7, 1'b1, 1);  // R7 two lines, R2 deferral
    run_reset(16'hFF07, 1'b1, 0);  // R7 all five lines
    run_reset(16'hFFAF, 1'b1, 2);  // R7 broken run, R3 timeout
    run_reset(16'hF7FF, 1'b0, 0);  // R8 test mode and external clock
    run_reset(16'h0000, 1'b1, 1);  // all alternates
    run_reset(16'hFFFF, 1'b1, 0);  // all defaults

    chk("R9 all captures consumed", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule